// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-side output path of a synchronous burst SRAM. Chip enables and the read/write control are captured in an input register on the rising clock edge. The memory array supplies the word for a captured read during the following cycle. The block then decides when that word appears on the data bus. A static mode pin selects between two paths. In flow-through mode the array word goes straight to the drivers. In pipeline mode a rising-edge output register sits in the path, which adds one cycle to the first access and still delivers one word per cycle during a burst.

Deselect and non-read cycles never pass through the array stage. They take the output drivers off one stage earlier than a read would bring data. The bus therefore releases on the same edge that a following read's data would otherwise appear, which is single-cycle-deselect behaviour.

The output enable and the sleep input gate the drivers with no clock involved. While sleep is high, the capture and output registers hold their contents, so a word waiting in the pipeline is still there when sleep is released.

Top module: `sram_rd_out_stage`

## Requirements
- R1: A synchronous active-low reset clears the captured command to deselect and empties the output register, so `dq_drive` is low in the cycle after the reset edge.
- R2: With `pipe_mode` low (flow-through), a read captured at edge n makes `dq_drive` high in the cycle after edge n, and `dq` equals `mem_rdata` in that same cycle.
- R3: With `pipe_mode` high (pipeline), a read captured at edge n makes `dq_drive` high in the cycle after edge n+1. In that cycle, `dq` carries the `mem_rdata` value that was present between edges n and n+1.
- R4: Reads captured on consecutive edges give one new word per cycle in both modes, with no gap between words.
- R5: A cycle counts as selected only when `ce_n` is 0 and `ce_alt` is at its active level (1 when CE_ALT_HIGH=1). A read request in any other cycle is captured as a deselect and produces no drive.
- R6: A deselect captured at edge n turns `dq_drive` off in the cycle after edge n in flow-through mode. In pipeline mode it turns the drive off in the cycle after edge n+1, which is the same edge at which a read's data would appear.
- R7: A selected cycle with `rd_en` low (a non-read command) turns the drivers off with the same timing as a deselect.
- R8: `oe_n` high forces `dq_drive` low in the same cycle, with no clock edge needed. When `oe_n` returns low, pending read data drives again.
- R9: `sleep` high forces `dq_drive` low in the same cycle. Edges sampled with `sleep` high change neither the captured command nor the output register, so a read requested during sleep is dropped. After release, the word that was waiting drives again with its original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | Static mode: 1 = pipeline (output register in path), 0 = flow-through |
| ce_n | input | 1 | Active-low chip enable, sampled at the clock edge |
| ce_alt | input | 1 | Second chip enable; its active level is set by CE_ALT_HIGH |
| rd_en | input | 1 | 1 = read, 0 = non-read command when selected; sampled at the clock edge |
| mem_rdata | input | DATA_W | Array word for the most recently captured read |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous low-power input; gates the drivers and freezes the stage |
| dq | output | DATA_W | Tri-state data bus, high impedance when not driving |
| dq_drive | output | 1 | High while `dq` is being driven |

## Verification
The bench builds the block with DATA_W=18 and CE_ALT_HIGH=1. The 18-bit word lets a changing pattern be placed on `mem_rdata` every cycle, so any off-by-one latency or stale word shows up as a wrong value on `dq`. The active-high second enable makes both enable polarities visible at the ports. The bench runs the same command sequences once in flow-through mode and once in pipeline mode, with a reset between the runs. This exposes the one-edge latency difference between the modes. It also shows where the single-cycle-deselect release lands relative to back-to-back reads.

// File: rtl/sram_rdout_pkg.sv
`timescale 1ns/1ps
// Package: shared command encoding for the SRAM read output stage.
// Assumes: commands are decoded once, at the input register.
package sram_rdout_pkg;

    // Command held in the input register after a clock edge.
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,   // chip not selected
        CMD_READ  = 2'd1,   // selected read
        CMD_OTHER = 2'd2    // selected, but not a read
    } cmd_e;

endpackage

// File: rtl/sram_cmd_capture.sv
`timescale 1ns/1ps
// Module: sram_cmd_capture
// Input register of the stage. On each rising edge it decodes the chip
// enables and the read control into one command and holds it for a cycle.
// Assumes: the second enable's polarity is fixed by CE_ALT_HIGH; while
// sleep is high the register holds (no new command is accepted).
module sram_cmd_capture
    import sram_rdout_pkg::*;
#(
    parameter bit CE_ALT_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic ce_n,
    input  logic ce_alt,
    input  logic rd_en,
    output cmd_e cmd_q,
    output logic cap_read
);

    logic alt_ok;
    logic selected;

    // Pick the active level of the second enable at elaboration time.
    generate
        if (CE_ALT_HIGH) begin : g_alt_high
            assign alt_ok = ce_alt;
        end else begin : g_alt_low
            assign alt_ok = ~ce_alt;
        end
    endgenerate

    // Selected only when every enable condition is true.
    assign selected = ~ce_n & alt_ok;

    // Register the decoded command; hold it while sleeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
        end else if (!sleep) begin
            if (!selected)  cmd_q <= CMD_DESEL;
            else if (rd_en) cmd_q <= CMD_READ;
            else            cmd_q <= CMD_OTHER;
        end
    end

    // Flag for the read path.
    assign cap_read = (cmd_q == CMD_READ);

    // R5: an edge that saw ce_n high (awake) never captures a read.
    a_r5_ce_n_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) && !$past(sleep)) |-> !cap_read);

    // R5: an edge that saw the second enable inactive never captures a read.
    a_r5_alt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_alt) != CE_ALT_HIGH && !$past(sleep)) |-> !cap_read);

    // R9: a sleeping edge leaves the captured command unchanged.
    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep) && $past(rst_n)) |-> $stable(cmd_q));

endmodule

// File: rtl/sram_rd_datapath.sv
`timescale 1ns/1ps
// Module: sram_rd_datapath
// Read data path. Flow-through passes the array word and the captured read
// flag straight on. Pipeline places a rising-edge register on both.
// Non-read commands clear the valid register, so deselect reaches the
// drivers without passing through the array stage.
// Assumes: pipe_mode is static while running; sleep freezes both registers.
module sram_rd_datapath #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              pipe_mode,
    input  logic              cap_read,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_valid
);

    logic [DATA_W-1:0] out_q;
    logic              vld_q;

    // Output register: load the array word on a read, track validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else if (!sleep) begin
            vld_q <= cap_read;
            if (cap_read) out_q <= mem_rdata;
        end
    end

    // Mode select: registered path or bypass.
    always_comb begin
        if (pipe_mode) begin
            rd_word  = out_q;
            rd_valid = vld_q;
        end else begin
            rd_word  = mem_rdata;
            rd_valid = cap_read;
        end
    end

    // R3: an awake read edge moves the array word into the output register.
    a_r3_word_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cap_read) && !$past(sleep) && $past(rst_n)) |-> out_q == $past(mem_rdata));

    // R9: sleeping edges leave the output register untouched.
    a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sleep) && $past(rst_n)) |-> ($stable(out_q) && $stable(vld_q)));

endmodule

// File: rtl/sram_drive_gate.sv
`timescale 1ns/1ps
// Module: sram_drive_gate
// Asynchronous driver gating. The bus is driven only with a valid read
// word, output enable asserted and sleep low.
// Assumes: oe_n and sleep may change at any time; no clock is involved.
module sram_drive_gate #(
    parameter int DATA_W = 18
) (
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    input  logic              sleep,
    output logic              drive,
    output logic [DATA_W-1:0] drive_word
);

    // Combine the three drive conditions.
    always_comb begin
        drive      = rd_valid & ~oe_n & ~sleep;
        drive_word = rd_word;
    end

endmodule

// File: rtl/sram_rd_out_stage.sv
`timescale 1ns/1ps
// Module: sram_rd_out_stage (top)
// Read output stage of a synchronous burst SRAM: input command register,
// pipeline/flow-through data path with single-cycle deselect, and
// asynchronous gating of the tri-state bus.
// Assumes: mem_rdata holds the word for the read captured at the last edge;
// pipe_mode is static during operation.
module sram_rd_out_stage #(
    parameter int DATA_W      = 18,
    parameter bit CE_ALT_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              ce_n,
    input  logic              ce_alt,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] dq,
    output logic              dq_drive
);
    import sram_rdout_pkg::*;

    cmd_e              cmd_q;
    logic              cap_read;
    logic [DATA_W-1:0] rd_word;
    logic              rd_valid;
    logic [DATA_W-1:0] drive_word;

    sram_cmd_capture #(.CE_ALT_HIGH(CE_ALT_HIGH)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .ce_n     (ce_n),
        .ce_alt   (ce_alt),
        .rd_en    (rd_en),
        .cmd_q    (cmd_q),
        .cap_read (cap_read)
    );

    sram_rd_datapath #(.DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .pipe_mode (pipe_mode),
        .cap_read  (cap_read),
        .mem_rdata (mem_rdata),
        .rd_word   (rd_word),
        .rd_valid  (rd_valid)
    );

    sram_drive_gate #(.DATA_W(DATA_W)) u_gate (
        .rd_valid   (rd_valid),
        .rd_word    (rd_word),
        .oe_n       (oe_n),
        .sleep      (sleep),
        .drive      (dq_drive),
        .drive_word (drive_word)
    );

    // Tri-state bus: release to high impedance when not driving.
    assign dq = dq_drive ? drive_word : {DATA_W{1'bz}};

    // R1: the cycle after a reset edge never drives.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> !dq_drive);

    // R2: flow-through read, enabled and awake, drives the array word.
    a_r2_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && cmd_q == CMD_READ && !oe_n && !sleep) |->
        (dq_drive && drive_word == mem_rdata));

    // R6/R7: in pipeline mode an awake non-read edge releases the bus next cycle.
    a_r6_pipe_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(rst_n) && !$past(sleep) && $past(cmd_q) != CMD_READ) |-> !dq_drive);

    // R8: output enable high keeps the bus off.
    a_r8_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);

    // R9: sleep keeps the bus off.
    a_r9_sleep_gates: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_drive);

endmodule

// File: tb/sram_rd_out_stage_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes one expected item per cycle,
// the monitor pops and compares it against the ports mid-cycle.
module sram_rd_out_stage_tb;

    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          ce_n = 1'b1;
    logic          ce_alt = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          oe_n = 1'b1;
    logic          sleep = 1'b0;
    wire  [DW-1:0] dq;
    wire           dq_drive;

    sram_rd_out_stage #(.DATA_W(DW), .CE_ALT_HIGH(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ce_n(ce_n),
        .ce_alt(ce_alt), .rd_en(rd_en), .mem_rdata(mem_rdata),
        .oe_n(oe_n), .sleep(sleep), .dq(dq), .dq_drive(dq_drive)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    typedef struct {
        logic          drive;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Bench model state (from the requirements).
    logic          m_a = 0;       // read captured at the last edge
    logic          m_b = 0;       // output-register valid
    logic [DW-1:0] m_q = '0;      // output-register word
    logic          p_rd = 0, p_slp = 0, p_rst = 0;  // values seen by next edge
    int            cyc = 0;

    function automatic logic [DW-1:0] word_of(int c);
        return DW'(c * 1237 + 91);
    endfunction

    // One cycle: account for the edge, apply inputs, push expectation.
    // cn/ca/rd/rst apply to the next edge; oe/slp apply to this cycle too.
    task automatic step(input logic cn, input logic ca, input logic rd,
                        input logic oe, input logic slp, input logic rst,
                        input string req);
        exp_t e;
        @(posedge clk);
        if (!p_rst) begin
            m_a = 0; m_b = 0; m_q = '0;
        end else if (!p_slp) begin
            m_b = m_a;
            if (m_a) m_q = mem_rdata;
            m_a = p_rd;
        end
        #1;
        cyc++;
        mem_rdata = word_of(cyc);
        ce_n = cn; ce_alt = ca; rd_en = rd; oe_n = oe; sleep = slp; rst_n = rst;
        p_rd = !cn && ca && rd; p_slp = slp; p_rst = rst;
        if (pipe_mode) begin
            e.drive = m_b && !oe && !slp;
            e.data  = m_q;
        end else begin
            e.drive = m_a && !oe && !slp;
            e.data  = mem_rdata;
        end
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic rd(input string req);  step(0, 1, 1, 0, 0, 1, req); endtask
    task automatic idle(input string req); step(1, 1, 1, 0, 0, 1, req); endtask

    // Monitor: compare mid-cycle, away from the edges.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (dq_drive !== e.drive) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: dq_drive=%b expected %b", e.req, cyc, dq_drive, e.drive);
                end else if (e.drive && dq !== e.data) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: dq=%h expected %h", e.req, cyc, dq, e.data);
                end
            end
        end
    end

    task automatic run_mode(input logic mode);
        pipe_mode = mode;
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        idle("R1"); idle("R1");
        // single read
        rd(mode ? "R3" : "R2"); idle("R6"); idle(mode ? "R3" : "R2"); idle("R6");
        // burst
        rd("R4"); rd("R4"); rd("R4"); rd("R4"); idle("R4"); idle("R6"); idle("R6");
        // deselect by second enable, then ce_n
        rd("R5"); step(0, 0, 1, 0, 0, 1, "R5"); rd("R5"); step(1, 0, 1, 0, 0, 1, "R5");
        idle("R5"); idle("R5");
        // read then deselect right after (release timing)
        rd("R6"); idle("R6"); idle("R6"); idle("R6");
        // read then non-read
        rd("R7"); step(0, 1, 0, 0, 0, 1, "R7"); step(0, 1, 0, 0, 0, 1, "R7"); idle("R7");
        // output enable toggling around a burst
        rd("R8"); step(0, 1, 1, 1, 0, 1, "R8"); step(0, 1, 1, 0, 0, 1, "R8");
        step(1, 1, 1, 1, 0, 1, "R8"); idle("R8"); idle("R8");
        // sleep: hold a pending word, drop a read issued while asleep
        rd("R9"); step(0, 1, 1, 0, 1, 1, "R9"); step(0, 1, 1, 0, 1, 1, "R9");
        step(1, 1, 1, 0, 0, 1, "R9"); idle("R9"); idle("R9"); idle("R9");
        // reset in the middle of a burst
        rd("R1"); rd("R1"); step(1, 0, 0, 0, 0, 0, "R1"); idle("R1"); idle("R1"); idle("R1");
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule